// File: doc/BRIEF.md
# Dual-Port RAM with Collision Busy Arbitration

This block is a clocked memory of 9-bit words with two independent access ports, called left and right. Each port has its own address, write data, read data, write select, output enable and a pair of enables. One enable is active low and the other is active high. Both ports may read or write any word in the same cycle. Read data is registered and comes with a valid flag, which takes the place of a tri-state data bus: when the flag is low, the data output is zero.

When both ports are selected on the same address, an arbiter decides which port keeps the word and raises a busy flag toward the other port. A write from a port that is flagged busy is dropped. Reads are never blocked. A master strap picks where the busy flags come from:
- In master mode they come from the internal arbiter.
- In slave mode they come from outside, so several of these memories can be placed side by side to form a wider word and all obey one master's decision.

Top module: `dpr_busy_ram`

## Requirements
- R1: A port is selected only when its low-active enable is 0 and its high-active enable is 1. For any other enable pair, the port writes nothing and its read-valid flag is 0 in the following cycle, with read data 0.
- R2: A selected port with write select low (`*_we_n` = 0) and no busy flag stores its 9-bit write data at its address. Its read-valid flag is 0 in the cycle after the write.
- R3: A selected port with `*_we_n` = 1 and `*_oe_n` = 0 returns the addressed word one clock later, with read-valid 1. The word returned is the content before any write in the same cycle.
- R4: With `*_oe_n` = 1, the port's read-valid flag and read data are 0 in the next cycle, whatever the other controls are.
- R5: Both ports work in the same cycle without interfering. Two writes to different addresses both commit, and two reads both return their words.
- R6: In master mode, a busy flag is raised only when both ports are selected on the same address in that cycle. The two busy flags are never raised together.
- R7: A port counts as continuing when it was selected on the same address in the previous cycle.
  - When a collision occurs and only one port is continuing, the other port is flagged busy.
  - When both ports are continuing, the port flagged in the previous cycle stays flagged.
- R8: On a collision where neither port is continuing (an exact tie), the right port is flagged busy and the left port is not.
- R9: A write from a port whose busy flag is raised does not change memory.
- R10: In slave mode (`is_master` = 0), each busy output copies the matching busy input and no internal arbitration applies. A raised busy input drops that port's write.
- R11: When both ports write the same address in one cycle and neither is busy, the left port's data is stored.
- R12: After reset, both read-valid flags and both read-data outputs are 0. In master mode, both busy outputs are 0 while the ports are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | 1: busy generated internally; 0: busy taken from inputs |
| l_addr | input | AW | Left address |
| l_wdata | input | 9 | Left write data |
| l_we_n | input | 1 | Left write select, 0 = write, 1 = read |
| l_oe_n | input | 1 | Left output enable, active low |
| l_en_n | input | 1 | Left enable, active low |
| l_en | input | 1 | Left enable, active high |
| l_busy_i | input | 1 | Left busy from an external master (slave mode) |
| l_busy_o | output | 1 | Left busy flag, always driven |
| l_rdata | output | 9 | Left read data, 0 when not valid |
| l_rvalid | output | 1 | Left read data valid |
| r_addr | input | AW | Right address |
| r_wdata | input | 9 | Right write data |
| r_we_n | input | 1 | Right write select, 0 = write, 1 = read |
| r_oe_n | input | 1 | Right output enable, active low |
| r_en_n | input | 1 | Right enable, active low |
| r_en | input | 1 | Right enable, active high |
| r_busy_i | input | 1 | Right busy from an external master (slave mode) |
| r_busy_o | output | 1 | Right busy flag, always driven |
| r_rdata | output | 9 | Right read data, 0 when not valid |
| r_rvalid | output | 1 | Right read data valid |

## Verification
The bench aims at the collision cases.

- **Tie on a same-address write:** an arbiter that favoured the wrong side would leave the right port's data in memory.
- **Established reader against a newcomer:** a design that ignored arrival order would flag the port that was already holding the word.
- **Collision held for a further cycle:** a design that forgot the previous loser would hand the word to the other side.
- **Slave mode:** a design that kept its own arbiter running would drop writes that the external master had allowed.
- **Enable pairs and output enable:** the three wrong enable pairs and a raised output enable each show a write or a read that should not have happened.
- **Read beside a colliding write:** a design that read after the write would return the new word instead of the old one.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic sel;
    logic wr;
    logic rd;
  } port_ctl_t;
endpackage

// File: rtl/dpr_port_decode.sv
module dpr_port_decode (
  input  logic                en_n,
  input  logic                en,
  input  logic                we_n,
  input  logic                oe_n,
  output dpr_pkg::port_ctl_t  ctl
);
  always_comb begin
    ctl.sel = !en_n && en;
    ctl.wr  = ctl.sel && !we_n;
    ctl.rd  = ctl.sel && we_n && !oe_n;
  end
endmodule

// File: rtl/dpr_arbiter.sv
module dpr_arbiter #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_l,
  input  logic          sel_r,
  input  logic [AW-1:0] addr_l,
  input  logic [AW-1:0] addr_r,
  output logic          lose_l,
  output logic          lose_r
);
  logic          prev_sel_l_q, prev_sel_r_q, prev_lose_l_q;
  logic [AW-1:0] prev_addr_l_q, prev_addr_r_q;
  logic          prev_sel_l_d, prev_sel_r_d, prev_lose_l_d;
  logic [AW-1:0] prev_addr_l_d, prev_addr_r_d;
  logic          cont_l, cont_r, collide;

  always_comb begin
    collide = sel_l && sel_r && (addr_l == addr_r);
    cont_l  = sel_l && prev_sel_l_q && (prev_addr_l_q == addr_l);
    cont_r  = sel_r && prev_sel_r_q && (prev_addr_r_q == addr_r);
    lose_l  = collide && ((cont_r && !cont_l) || (cont_l && cont_r && prev_lose_l_q));
    lose_r  = collide && !lose_l;
    prev_sel_l_d  = sel_l;
    prev_sel_r_d  = sel_r;
    prev_addr_l_d = addr_l;
    prev_addr_r_d = addr_r;
    prev_lose_l_d = lose_l;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sel_l_q  <= 1'b0;
      prev_sel_r_q  <= 1'b0;
      prev_lose_l_q <= 1'b0;
      prev_addr_l_q <= '0;
      prev_addr_r_q <= '0;
    end else begin
      prev_sel_l_q  <= prev_sel_l_d;
      prev_sel_r_q  <= prev_sel_r_d;
      prev_lose_l_q <= prev_lose_l_d;
      prev_addr_l_q <= prev_addr_l_d;
      prev_addr_r_q <= prev_addr_r_d;
    end
  end

  AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(lose_l && lose_r)); // R6
  AST_BUSY_NEEDS_COLLISION: assert property (@(posedge clk) disable iff (!rst_n)
    (lose_l || lose_r) |-> (sel_l && sel_r && addr_l == addr_r)); // R6
  AST_TIE_TO_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && !cont_l && !cont_r) |-> (lose_r && !lose_l)); // R8
  AST_LOSER_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && cont_l && cont_r) |-> (lose_l == $past(lose_l))); // R7
endmodule

// File: rtl/dpr_storage.sv
module dpr_storage #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           wr,
  input  logic [1:0]           rd,
  input  logic [1:0][AW-1:0]   addr,
  input  dpr_pkg::word_t [1:0] wdata,
  output dpr_pkg::word_t [1:0] rdata,
  output logic [1:0]           rvalid
);
  import dpr_pkg::*;

  localparam int LEFT  = 0;
  localparam int RIGHT = 1;

  word_t mem [DEPTH];

  // Right first, left last: when both write one word, the left value lands.
  always_ff @(posedge clk) begin
    if (wr[RIGHT]) mem[addr[RIGHT]] <= wdata[RIGHT];
    if (wr[LEFT])  mem[addr[LEFT]]  <= wdata[LEFT];
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    word_t rdata_d;
    logic  rvalid_d;

    always_comb begin
      rvalid_d = rd[p];
      rdata_d  = rd[p] ? mem[addr[p]] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdata[p]  <= '0;
        rvalid[p] <= 1'b0;
      end else begin
        rdata[p]  <= rdata_d;
        rvalid[p] <= rvalid_d;
      end
    end

    AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid[p] |-> $past(rd[p])); // R4
    AST_DATA_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rvalid[p] |-> (rdata[p] == '0)); // R1
  end
endmodule

// File: rtl/dpr_busy_ram.sv
module dpr_busy_ram #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_master,
  input  logic [AW-1:0] l_addr,
  input  logic [8:0]    l_wdata,
  input  logic          l_we_n,
  input  logic          l_oe_n,
  input  logic          l_en_n,
  input  logic          l_en,
  input  logic          l_busy_i,
  output logic          l_busy_o,
  output logic [8:0]    l_rdata,
  output logic          l_rvalid,
  input  logic [AW-1:0] r_addr,
  input  logic [8:0]    r_wdata,
  input  logic          r_we_n,
  input  logic          r_oe_n,
  input  logic          r_en_n,
  input  logic          r_en,
  input  logic          r_busy_i,
  output logic          r_busy_o,
  output logic [8:0]    r_rdata,
  output logic          r_rvalid
);
  import dpr_pkg::*;

  port_ctl_t          ctl_l, ctl_r;
  logic               lose_l, lose_r;
  logic               busy_l, busy_r;
  logic [1:0]         wr_commit, rd_req;
  logic [1:0][AW-1:0] addr_v;
  word_t [1:0]        wdata_v, rdata_v;
  logic [1:0]         rvalid_v;

  dpr_port_decode u_dec_l (
    .en_n(l_en_n), .en(l_en), .we_n(l_we_n), .oe_n(l_oe_n), .ctl(ctl_l)
  );
  dpr_port_decode u_dec_r (
    .en_n(r_en_n), .en(r_en), .we_n(r_we_n), .oe_n(r_oe_n), .ctl(ctl_r)
  );

  dpr_arbiter #(.AW(AW)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .sel_l(ctl_l.sel), .sel_r(ctl_r.sel),
    .addr_l(l_addr), .addr_r(r_addr),
    .lose_l(lose_l), .lose_r(lose_r)
  );

  always_comb begin
    busy_l       = is_master ? lose_l : l_busy_i;
    busy_r       = is_master ? lose_r : r_busy_i;
    wr_commit[0] = ctl_l.wr && !busy_l;
    wr_commit[1] = ctl_r.wr && !busy_r;
    rd_req[0]    = ctl_l.rd;
    rd_req[1]    = ctl_r.rd;
    addr_v[0]    = l_addr;
    addr_v[1]    = r_addr;
    wdata_v[0]   = l_wdata;
    wdata_v[1]   = r_wdata;
  end

  dpr_storage #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .wr(wr_commit), .rd(rd_req), .addr(addr_v), .wdata(wdata_v),
    .rdata(rdata_v), .rvalid(rvalid_v)
  );

  assign l_busy_o = busy_l;
  assign r_busy_o = busy_r;
  assign l_rdata  = rdata_v[0];
  assign r_rdata  = rdata_v[1];
  assign l_rvalid = rvalid_v[0];
  assign r_rvalid = rvalid_v[1];

  AST_BUSY_BLOCKS_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && lose_l) |-> !wr_commit[0]); // R9
endmodule

// File: tb/sim_dpr_busy_ram.sv
`timescale 1ns/1ps
module sim_dpr_busy_ram;
  localparam int DEPTH = 512;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0, is_master = 1;
  logic [AW-1:0] l_addr, r_addr;
  logic [8:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_we_n, l_oe_n, l_en_n, l_en, l_busy_i, l_busy_o, l_rvalid;
  logic r_we_n, r_oe_n, r_en_n, r_en, r_busy_i, r_busy_o, r_rvalid;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dpr_busy_ram #(.DEPTH(DEPTH)) u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic set_l(logic en_n, logic en, logic we_n, logic oe_n, logic [AW-1:0] a, logic [8:0] d);
    l_en_n = en_n; l_en = en; l_we_n = we_n; l_oe_n = oe_n; l_addr = a; l_wdata = d;
  endtask

  task automatic set_r(logic en_n, logic en, logic we_n, logic oe_n, logic [AW-1:0] a, logic [8:0] d);
    r_en_n = en_n; r_en = en; r_we_n = we_n; r_oe_n = oe_n; r_addr = a; r_wdata = d;
  endtask

  task automatic idle();
    set_l(1, 0, 1, 1, '0, '0);
    set_r(1, 0, 1, 1, '0, '0);
  endtask

  task automatic wr_l(logic [AW-1:0] a, logic [8:0] d);
    idle(); set_l(0, 1, 0, 1, a, d); step(); idle();
  endtask

  task automatic rd_chk_l(logic [AW-1:0] a, logic [8:0] exp, string tag);
    idle(); set_l(0, 1, 1, 0, a, '0); step();
    chk({tag, " left valid"}, l_rvalid, 1);
    chk({tag, " left data"}, l_rdata, exp);
    idle();
  endtask

  task automatic rd_chk_r(logic [AW-1:0] a, logic [8:0] exp, string tag);
    idle(); set_r(0, 1, 1, 0, a, '0); step();
    chk({tag, " right valid"}, r_rvalid, 1);
    chk({tag, " right data"}, r_rdata, exp);
    idle();
  endtask

  task automatic t_reset();
    chk("R12 l_rvalid", l_rvalid, 0);
    chk("R12 r_rvalid", r_rvalid, 0);
    chk("R12 l_rdata", l_rdata, 0);
    chk("R12 r_rdata", r_rdata, 0);
    chk("R12 l_busy_o", l_busy_o, 0);
    chk("R12 r_busy_o", r_busy_o, 0);
  endtask

  task automatic t_basic();
    for (int i = 0; i < 4; i++) begin
      idle(); set_l(0, 1, 0, 0, AW'(i * 37 + 5), 9'(9'h100 + i * 19)); step();
      chk("R2 no valid after write", l_rvalid, 0);
    end
    wr_l(AW'(DEPTH - 1), 9'h1A5);
    for (int i = 0; i < 4; i++)
      rd_chk_r(AW'(i * 37 + 5), 9'(9'h100 + i * 19), "R2 R3 readback");
    rd_chk_r(AW'(DEPTH - 1), 9'h1A5, "R3 top address");
  endtask

  task automatic t_deselect();
    wr_l(10, 9'h0AA);
    set_l(1, 1, 0, 0, 10, 9'h155); step(); chk("R1 en_n high", l_rvalid, 0);
    set_l(0, 0, 0, 0, 10, 9'h155); step(); chk("R1 en low", l_rvalid, 0);
    set_l(1, 0, 0, 0, 10, 9'h155); step(); chk("R1 both off", l_rvalid, 0);
    set_l(1, 1, 1, 0, 10, 9'h000); step();
    chk("R1 deselected read valid", l_rvalid, 0);
    chk("R1 deselected read data", l_rdata, 0);
    rd_chk_r(10, 9'h0AA, "R1 no write when deselected");
  endtask

  task automatic t_oe();
    idle(); set_l(0, 1, 1, 1, 10, '0); step();
    chk("R4 oe high valid", l_rvalid, 0);
    chk("R4 oe high data", l_rdata, 0);
    idle(); set_l(0, 1, 0, 0, 10, 9'h0AB); step();
    chk("R2 write with oe low", l_rvalid, 0);
    idle();
    rd_chk_r(10, 9'h0AB, "R2 write with oe low stored");
  endtask

  task automatic t_parallel();
    idle(); step();
    set_l(0, 1, 0, 1, 20, 9'h011); set_r(0, 1, 0, 1, 21, 9'h1EE); #1;
    chk("R6 no busy l", l_busy_o, 0);
    chk("R6 no busy r", r_busy_o, 0);
    step();
    set_l(0, 1, 1, 0, 21, '0); set_r(0, 1, 1, 0, 20, '0); step();
    chk("R5 left reads 21", l_rdata, 9'h1EE);
    chk("R5 right reads 20", r_rdata, 9'h011);
    chk("R5 both valid", {l_rvalid, r_rvalid}, 2'b11);
    idle(); step();
    set_l(0, 1, 0, 1, 20, 9'h077); set_r(0, 1, 1, 0, 20, '0); #1;
    chk("R8 tie flags right", {l_busy_o, r_busy_o}, 2'b01);
    step();
    chk("R3 old data on read beside write", r_rdata, 9'h011);
    idle();
    rd_chk_r(20, 9'h077, "R3 write committed");
  endtask

  task automatic t_tie();
    idle(); step();
    set_l(0, 1, 0, 1, 30, 9'h0C3); set_r(0, 1, 0, 1, 30, 9'h13C); #1;
    chk("R8 tie busy", {l_busy_o, r_busy_o}, 2'b01);
    step(); idle();
    rd_chk_l(30, 9'h0C3, "R9 loser write dropped");
  endtask

  task automatic t_hold();
    wr_l(40, 9'h040);
    idle(); set_r(0, 1, 1, 0, 40, '0); step();
    set_l(0, 1, 0, 1, 40, 9'h1FF); #1;
    chk("R7 newcomer left flagged", {l_busy_o, r_busy_o}, 2'b10);
    step();
    chk("R5 holder still reads", r_rdata, 9'h040);
    #1 chk("R7 loser stays flagged", {l_busy_o, r_busy_o}, 2'b10);
    step(); idle(); step();
    rd_chk_r(40, 9'h040, "R9 left write dropped");
    idle(); step();
    set_l(0, 1, 1, 0, 40, '0); step();
    set_r(0, 1, 0, 1, 40, 9'h0F0); #1;
    chk("R7 newcomer right flagged", {l_busy_o, r_busy_o}, 2'b01);
    step(); idle(); step();
    rd_chk_l(40, 9'h040, "R9 right write dropped");
  endtask

  task automatic t_slave();
    wr_l(50, 9'h050);
    is_master = 0; idle(); step();
    l_busy_i = 1; set_l(0, 1, 0, 1, 50, 9'h0D5); #1;
    chk("R10 busy echo", {l_busy_o, r_busy_o}, 2'b10);
    step(); l_busy_i = 0; idle();
    rd_chk_r(50, 9'h050, "R10 busy input drops write");
    idle(); step();
    set_l(0, 1, 0, 1, 50, 9'h123); set_r(0, 1, 0, 1, 50, 9'h0BE); #1;
    chk("R10 no internal arbitration", {l_busy_o, r_busy_o}, 2'b00);
    step(); idle();
    rd_chk_l(50, 9'h123, "R11 left wins double write");
    is_master = 1; idle(); step();
  endtask

  initial begin
    idle(); l_busy_i = 0; r_busy_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_basic();
    t_deselect();
    t_oe();
    t_parallel();
    t_tie();
    t_hold();
    t_slave();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule